// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Control

This block is the digital side of a 10-bit sampling converter inside a codec companion chip. A host reaches it through a simple register bus with a 4-bit index. A 16-bit control word holds the converter enable, a 3-bit input selector, a sync enable and a start bit. A data word returns the latest result together with a valid flag. A fixed identity word lets software confirm which variant it is talking to.

Before the first conversion, a newly enabled converter first waits out a startup interval. A start request then runs a fixed number of clocks of input selection, an optional wait for an external sync trigger, and a fixed number of clocks of conversion. At the end, the block captures the sample input into the data word, sets the valid flag, and emits a one-cycle done event for the interrupt logic. The analog converter is outside the block and appears as a sample bus. The selected input is driven out on a channel bus so that the analog multiplexer can follow it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, every register reads zero except index 12, which returns the identity constant (0x1004 by default, 0x1005 with the variant parameter set). Index 10 returns the last value written to it. Any unused index reads zero. Read data appears one clock after the index is presented.
- R2: A conversion is requested only by a write to index 10 that sets bit 15 (enable) and sets bit 7 (start) while the stored bit 7 is 0. Rewriting bit 7 as 1 when it is already 1 requests nothing.
- R3: With sync disabled (bit 0 = 0) and the startup interval complete, `adc_done` is high for exactly one clock, SELECT_CYC+CONVERT_CYC (default 153) clocks after the edge that accepted the start write.
- R4: Index 11 reads bit 15 = valid, bits 14:5 = the 10-bit sample captured on the last conversion clock, and bits 4:0 = 0. Valid is 1 from the cycle in which `adc_done` is high.
- R5: Valid returns to 0 on the edge at which a new conversion is launched.
- R6: With sync enabled (bit 0 = 1), the sequencer holds after the selection phase until `adc_sync_trig` is sampled high. `adc_done` follows CONVERT_CYC (default 102) clocks after that edge.
- R7: Once enable is set, a STARTUP_CYC clock interval (default 60) must pass before a conversion is launched. A start requested during this interval is held, and it launches on the first clock after the interval ends.
- R8: A write that clears bit 15 aborts any conversion in progress, clears valid and cancels a held start. No `adc_done` follows.
- R9: A start request made while a conversion is running is ignored. It produces no second `adc_done`.
- R10: `adc_chan` takes the value of bits 4:2 at launch and holds it until the next launch, even if the control word is rewritten.
- R11: A start write with bit 15 = 0 launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 4 | Register index for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| adc_sample | input | 10 | Converted value from the analog converter |
| adc_sync_trig | input | 1 | External trigger that releases a sync-held conversion |
| adc_chan | output | 3 | Input selected for the analog multiplexer |
| adc_done | output | 1 | One-cycle conversion-complete event |

## Verification
The hardest situations to reach from the ports are the ones where a request meets the sequencer in a state where it must not act at once. Examples are a start arriving while the startup interval is still running, and a start-bit toggle in the middle of a conversion. An enable clear that lands partway through a conversion is another. The stimulus produces the first case by issuing the start write on the clock right after the enable write. It produces the second by toggling the start bit off and on again while a conversion runs, and the third by clearing enable 50 clocks into a conversion. A scoreboard holds the exact cycle at which each `adc_done` is due, so an early, late, extra or missing event is reported as a failure.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 10;
  localparam int CHAN_W = 3;

  localparam logic [ADDR_W-1:0] IDX_CTRL = 4'd10;
  localparam logic [ADDR_W-1:0] IDX_DATA = 4'd11;
  localparam logic [ADDR_W-1:0] IDX_ID   = 4'd12;

  localparam int B_ENA     = 15;
  localparam int B_START   = 7;
  localparam int B_CHAN_LO = 2;
  localparam int B_SYNC    = 0;
  localparam int PAD_W     = REG_W - 1 - DATA_W;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SELECT  = 2'd1,
    PH_SYNC    = 2'd2,
    PH_CONVERT = 2'd3
  } phase_t;
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic              ena_nx,
  output logic              sync_nx,
  output logic [CHAN_W-1:0] chan_nx,
  output logic              start_req
);
  logic             wr_ctrl;
  logic [REG_W-1:0] ctrl_nx;

  assign wr_ctrl   = reg_wr && (reg_addr == IDX_CTRL);
  assign ctrl_nx   = wr_ctrl ? reg_wdata : ctrl_q;
  assign ena_nx    = ctrl_nx[B_ENA];
  assign sync_nx   = ctrl_nx[B_SYNC];
  assign chan_nx   = ctrl_nx[B_CHAN_LO +: CHAN_W];
  // a request is the 0->1 transition of the start bit, with enable set
  assign start_req = wr_ctrl && reg_wdata[B_START] && !ctrl_q[B_START]
                     && reg_wdata[B_ENA];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nx;
  end
endmodule

// File: rtl/adc_warmup.sv
module adc_warmup #(
  parameter int STARTUP_CYC = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic ena_nx,
  input  logic ena_q,
  output logic ready
);
  localparam int CW = $clog2(STARTUP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !ena_nx) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (ena_q && !ready) begin
      if (cnt == LAST) ready <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_seq_pkg::*;
#(
  parameter int SELECT_CYC  = 51,
  parameter int CONVERT_CYC = 102
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              abort,
  input  logic              ready,
  input  logic              sync_trig,
  input  logic              sync_nx,
  input  logic [CHAN_W-1:0] chan_nx,
  output phase_t            state,
  output logic [CHAN_W-1:0] chan,
  output logic              done,
  output logic              launch_now,
  output logic              finish_now
);
  localparam int MAXC = (SELECT_CYC > CONVERT_CYC) ? SELECT_CYC : CONVERT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SEL_LAST  = CW'(SELECT_CYC - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONVERT_CYC - 1);

  logic [CW-1:0] cnt;
  logic          pend;
  logic          sync_l;

  assign launch_now = (state == PH_IDLE) && !abort && ready && (start_req || pend);
  assign finish_now = (state == PH_CONVERT) && !abort && (cnt == CONV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      pend   <= 1'b0;
      sync_l <= 1'b0;
      chan   <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish_now;
      if (abort) begin
        state <= PH_IDLE;
        cnt   <= '0;
        pend  <= 1'b0;
      end else begin
        case (state)
          PH_IDLE: begin
            if (launch_now) begin
              state  <= PH_SELECT;
              cnt    <= '0;
              pend   <= 1'b0;
              chan   <= chan_nx;
              sync_l <= sync_nx;
            end else if (start_req) begin
              pend <= 1'b1;
            end
          end
          PH_SELECT: begin
            if (cnt == SEL_LAST) begin
              cnt   <= '0;
              state <= sync_l ? PH_SYNC : PH_CONVERT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_SYNC: begin
            if (sync_trig) begin
              cnt   <= '0;
              state <= PH_CONVERT;
            end
          end
          default: begin
            if (cnt == CONV_LAST) begin
              cnt   <= '0;
              state <= PH_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_result.sv
module adc_result
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              launch,
  input  logic              finish,
  input  logic [DATA_W-1:0] sample,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (abort || launch) begin
      valid <= 1'b0;
    end else if (finish) begin
      valid <= 1'b1;
      data  <= sample;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int STARTUP_CYC = 60,
  parameter int SELECT_CYC  = 51,
  parameter int CONVERT_CYC = 102,
  parameter bit ID_VARIANT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [9:0]        adc_sample,
  input  logic              adc_sync_trig,
  output logic [2:0]        adc_chan,
  output logic              adc_done
);
  localparam logic [REG_W-1:0] ID_VALUE = 16'h1004 + {15'd0, ID_VARIANT};

  logic [REG_W-1:0]  ctrl_q;
  logic              ena_nx, sync_nx, start_req;
  logic [CHAN_W-1:0] chan_nx;
  logic              warm_ready;
  phase_t            seq_state;
  logic              launch_now, finish_now;
  logic              res_valid;
  logic [DATA_W-1:0] res_sample;

  adc_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .ena_nx(ena_nx),
    .sync_nx(sync_nx), .chan_nx(chan_nx), .start_req(start_req)
  );

  adc_warmup #(.STARTUP_CYC(STARTUP_CYC)) u_warm (
    .clk(clk), .rst(rst), .ena_nx(ena_nx), .ena_q(ctrl_q[B_ENA]),
    .ready(warm_ready)
  );

  adc_phase_seq #(.SELECT_CYC(SELECT_CYC), .CONVERT_CYC(CONVERT_CYC)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .abort(!ena_nx),
    .ready(warm_ready), .sync_trig(adc_sync_trig), .sync_nx(sync_nx),
    .chan_nx(chan_nx), .state(seq_state), .chan(adc_chan),
    .done(adc_done), .launch_now(launch_now), .finish_now(finish_now)
  );

  adc_result u_res (
    .clk(clk), .rst(rst), .abort(!ena_nx), .launch(launch_now),
    .finish(finish_now), .sample(adc_sample), .valid(res_valid),
    .data(res_sample)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        IDX_CTRL: reg_rdata <= ctrl_q;
        IDX_DATA: reg_rdata <= {res_valid, res_sample, {PAD_W{1'b0}}};
        IDX_ID:   reg_rdata <= ID_VALUE;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic              wr_ena_bit,
  input logic [9:0]        adc_sample,
  input logic              adc_sync_trig,
  input logic [2:0]        adc_chan,
  input logic              adc_done,
  input phase_t            seq_state,
  input logic              res_valid,
  input logic [9:0]        res_sample,
  input logic              ena_nx,
  input logic              warm_ready
);
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    adc_done |=> !adc_done);

  // R4
  done_valid_chk: assert property (@(posedge clk) disable iff (rst)
    adc_done |-> (res_valid && res_sample == $past(adc_sample)));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == IDX_CTRL && !wr_ena_bit)
      |=> (!adc_done && !res_valid && seq_state == PH_IDLE));

  // R5
  launch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == PH_SELECT && $past(seq_state) == PH_IDLE) |-> !res_valid);

  // R6
  sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == PH_SYNC && !adc_sync_trig && ena_nx) |=> seq_state == PH_SYNC);

  // R7
  warm_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == PH_SELECT) |-> warm_ready);

  // R10
  chan_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state != PH_IDLE && $past(seq_state) != PH_IDLE) |-> $stable(adc_chan));
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wr_ena_bit(reg_wdata[15]), .adc_sample(adc_sample),
  .adc_sync_trig(adc_sync_trig), .adc_chan(adc_chan), .adc_done(adc_done),
  .seq_state(seq_state), .res_valid(res_valid), .res_sample(res_sample),
  .ena_nx(ena_nx), .warm_ready(warm_ready)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int STARTUP = 60;
  localparam int SEL     = 51;
  localparam int CONV    = 102;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [9:0]  adc_sample = 10'd0;
  logic        adc_sync_trig = 1'b0;
  logic [2:0]  adc_chan;
  logic        adc_done;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int done_count = 0;
  int last_wr = 0;
  bit finished = 1'b0;
  int exp_q[$];

  adc_seq_ctrl #(.STARTUP_CYC(STARTUP), .SELECT_CYC(SEL), .CONVERT_CYC(CONV)) i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_sample(adc_sample),
    .adc_sync_trig(adc_sync_trig), .adc_chan(adc_chan), .adc_done(adc_done)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = d;
    @(posedge clk); #1;
    last_wr = cyc;
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] idx, output logic [15:0] v);
    @(negedge clk);
    reg_addr = idx;
    @(posedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: pops expected completion cycles as done events appear
  always @(negedge clk) begin
    if (!rst && adc_done) begin
      done_count++;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9/R2: unexpected done actual=%0d expected=none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (cyc != e) begin
          bad++;
          $display("FAIL R3: done cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n0, cw, cs;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state and register map
    bus_read(4'd10, v); check("R1 ctrl reset", v, 16'h0000);
    bus_read(4'd11, v); check("R4 data reset", v, 16'h0000);
    bus_read(4'd12, v); check("R1 id", v, 16'h1004);
    bus_read(4'd13, v); check("R1 unused index", v, 16'h0000);
    check("R3 done idle", adc_done, 0);

    // R7 start during startup is held
    adc_sample = 10'h155;
    bus_write(16'h8000); cw = last_wr;
    bus_write(16'h8088);
    exp_q.push_back(cw + STARTUP + 1 + SEL + CONV);
    idle(120);
    @(negedge clk); check("R10 chan during conversion", adc_chan, 2);
    idle(120);
    check("R7 held start completed", done_count, 1);
    bus_read(4'd11, v); check("R4 data word", v, 16'h8000 | (16'h155 << 5));

    // R2 start bit already set: no conversion
    n0 = done_count;
    bus_write(16'h8088);
    idle(200);
    check("R2 no retrigger", done_count, n0);

    // R3 basic timing, R4 full-scale sample
    adc_sample = 10'h3FF;
    bus_write(16'h8014);
    bus_write(16'h8094);
    exp_q.push_back(last_wr + SEL + CONV);
    idle(160);
    check("R3 one done", done_count, n0 + 1);
    bus_read(4'd11, v); check("R4 full scale", v, 16'hFFE0);

    // R5 valid clears at launch; R9 busy restart ignored; R10 chan holds
    adc_sample = 10'h000;
    bus_write(16'h8004);
    bus_write(16'h8084);
    exp_q.push_back(last_wr + SEL + CONV);
    bus_read(4'd11, v); check("R5 valid cleared", v, 16'h7FE0);
    bus_write(16'h801C);
    bus_write(16'h809C);
    @(negedge clk); check("R10 chan held", adc_chan, 1);
    idle(360);
    check("R9 single done", done_count, n0 + 2);
    bus_read(4'd11, v); check("R4 zero sample", v, 16'h8000);

    // R6 sync-held conversion
    adc_sample = 10'h2AA;
    bus_write(16'h8001);
    bus_write(16'h8081);
    idle(300);
    check("R6 held for sync", done_count, n0 + 2);
    @(negedge clk) adc_sync_trig = 1'b1;
    @(posedge clk); #1 cs = cyc;
    exp_q.push_back(cs + CONV);
    @(negedge clk) adc_sync_trig = 1'b0;
    idle(110);
    check("R6 done after sync", done_count, n0 + 3);
    bus_read(4'd11, v); check("R6 sync result", v, 16'hD540);

    // R8 abort by clearing enable
    adc_sample = 10'h111;
    bus_write(16'h8000);
    bus_write(16'h8080);
    idle(50);
    bus_write(16'h0000);
    idle(200);
    check("R8 no done after abort", done_count, n0 + 3);
    bus_read(4'd11, v); check("R8 valid cleared", v, 16'h5540);

    // R11 start with enable clear
    bus_write(16'h0080);
    idle(300);
    check("R11 no conversion", done_count, n0 + 3);
    bus_read(4'd10, v); check("R1 ctrl readback", v, 16'h0080);
    check("R3 no pending expectations", exp_q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule